// File: doc/BRIEF.md
# Background Debug Command Sequencer

This block sits behind the bit-level serial layer of a single-wire debug port on a small 8-bit CPU. It receives the debug command stream as bytes on a valid/ready input. For each opcode it runs that command's own sequence of address, data, delay and status phases. Memory commands drive a byte-wide target memory port. Register commands use a simple CPU register read/write port. Replies (read data and status bytes) leave on a valid/ready output. The block also holds a debug status/control register and a 16-bit breakpoint register. It tracks whether the target is halted in active background mode, and it produces a timed reference pulse when the separate sync strobe is raised.

The sequencer has nine states. IDLE takes an opcode byte and decodes it. ADDR_HI and ADDR_LO collect a 16-bit address. DATA_IN collects one or two write bytes. INC_HX bumps the H:X register pair. MEM_WAIT holds the memory access for a fixed number of cycles. SEND_STAT returns the status byte. SEND_DATA returns one or two data bytes. DISCARD swallows the operands of a refused command.

The transitions are as follows. IDLE goes to ADDR_HI for addressed memory commands. It goes to MEM_WAIT for re-read, to DATA_IN for write-style commands, to SEND_DATA for status, breakpoint and register reads, to INC_HX for read-next, and to DISCARD for refused commands that carry operands. Commands that complete at once, and unknown opcodes, keep it in IDLE. ADDR_HI goes to ADDR_LO. ADDR_LO goes to DATA_IN for a write and to MEM_WAIT for a read. DATA_IN goes to MEM_WAIT for a memory write, to INC_HX for write-next, and to IDLE otherwise. INC_HX goes to MEM_WAIT. MEM_WAIT goes to SEND_STAT, SEND_DATA or IDLE. SEND_STAT goes to SEND_DATA for reads and to IDLE otherwise. SEND_DATA and DISCARD return to IDLE after their last byte.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset the block is idle and ready for an opcode, with no reply pending, no sync pulse, and background mode inactive. A status read (0xE4) then returns 0x00. The status byte layout is: bit 7 background-enable, bit 6 background-active, bit 5 acknowledge-enabled, bit 4 error, bits 3..0 zero.
- R2: Opcode 0x90 enters background mode only when background-enable is 1. With it 0 the opcode has no effect. The control write 0xC4 takes one byte whose bit 7 sets background-enable.
- R3: Register-access opcodes (0x08, 0x10, 0x18, 0x48–0x4F, 0x50, 0x51, 0x68–0x6F, 0x70, 0x71) received outside background mode are refused. Their operand bytes are swallowed, nothing is returned, no register or memory is written, and the error bit is set. A status read returns the error bit and then clears it.
- R4: Memory write 0xC0 takes a high address byte, a low address byte and a data byte, then writes that byte at the address. The write strobe stays active for the whole delay phase.
- R5: Memory read 0xE0 takes a high address byte and a low address byte, waits WAIT_CYCLES cycles with the read strobe active, and then returns the byte.
- R6: Read with status (0xE1) returns the status byte before the data byte. Write with status (0xC1) returns the status byte after its delay. Any output byte is held stable until it is accepted.
- R7: Re-read (0xE8) takes no address. It returns status and then the current byte at the address of the most recent memory read.
- R8: Breakpoint write 0xC2 takes two bytes, high first. Breakpoint read 0xE2 returns the two bytes, high first.
- R9: The 8-bit register commands (A: read 0x68, write 0x48; CCR: read 0x69, write 0x49) move one byte. The 16-bit ones (PC 0x6B/0x4B, H:X 0x6C/0x4C, SP 0x6F/0x4F) move two bytes, high first. The register select codes are A=0, CCR=1, PC=2, H:X=3, SP=4.
- R10: Read-next (0x70, with status 0x71) and write-next (0x50, with status 0x51) first write H:X+1 back to H:X and then access memory at that new value. The write variants take their data byte before the increment.
- R11: GO (0x08) and TAGGO (0x18) leave background mode with a one-cycle resume pulse. TRACE1 (0x10) leaves with a one-cycle step pulse and returns to background mode when the step-done input is seen.
- R12: A one-cycle sync strobe produces a sync pulse that is high for exactly SYNC_CYCLES cycles, starting the next cycle.
- R13: An unknown opcode is dropped without setting the error bit, and the next byte is decoded as an opcode.
- R14: Opcode 0xD5 sets the acknowledge-enabled bit and 0xD6 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Command byte available |
| rx_ready | output | 1 | Sequencer accepts a byte |
| rx_byte | input | 8 | Command, address or data byte |
| tx_valid | output | 1 | Reply byte available |
| tx_ready | input | 1 | Host takes the reply byte |
| tx_byte | output | 8 | Status or read data byte |
| sync_req | input | 1 | Request for a timing reference pulse |
| sync_pulse | output | 1 | Timing reference pulse |
| mem_addr | output | 16 | Target memory address |
| mem_re | output | 1 | Memory read strobe (delay phase) |
| mem_we | output | 1 | Memory write strobe (delay phase) |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| cpu_reg_sel | output | 3 | CPU register select |
| cpu_reg_we | output | 1 | CPU register write strobe |
| cpu_reg_wdata | output | 16 | CPU register write value |
| cpu_reg_rdata | input | 16 | CPU register read value |
| cpu_go | output | 1 | Resume execution pulse |
| cpu_step | output | 1 | Execute one instruction pulse |
| cpu_step_done | input | 1 | Single step completed |
| bg_active | output | 1 | Target halted in background mode |
| ack_en | output | 1 | Acknowledge protocol enabled |

## Verification
The hardest situation to reach is a refused register command whose operand bytes must be swallowed. In that case the next byte must still be decoded as a fresh opcode, and the memory and register state must show no trace of the refused bytes. The stimulus reaches it by sending a two-byte register write before background mode is ever enabled and then issuing a status read. Much later, after enabling and entering background mode, it reads the register back. Re-read is also awkward: it is driven after a status-variant read, and the byte at that address is then changed through a plain memory write, so the reply proves that the stored address was reused and the memory was accessed again.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    typedef enum logic [4:0] {
        K_BAD, K_STAT_RD, K_CTRL_WR, K_MEM_RD, K_MEM_WR, K_REREAD,
        K_BKPT_RD, K_BKPT_WR, K_BGND, K_ACK_ON, K_ACK_OFF, K_GO,
        K_TRACE, K_REG_RD, K_REG_WR, K_NEXT_RD, K_NEXT_WR
    } cmd_kind_t;

    typedef enum logic [2:0] {
        REG_A   = 3'd0,
        REG_CCR = 3'd1,
        REG_PC  = 3'd2,
        REG_HX  = 3'd3,
        REG_SP  = 3'd4
    } cpu_reg_t;

    typedef struct packed {
        cmd_kind_t  kind;
        logic       with_stat;
        logic       wide;
        logic       active_only;
        cpu_reg_t   reg_id;
        logic [1:0] n_in;
    } cmd_info_t;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR_HI, S_ADDR_LO, S_DIN, S_INC,
        S_WAIT, S_STAT, S_SEND, S_DISCARD
    } seq_state_t;

    function automatic logic kind_reads(cmd_kind_t k);
        return (k == K_MEM_RD) || (k == K_REREAD) || (k == K_NEXT_RD);
    endfunction

    function automatic logic kind_writes(cmd_kind_t k);
        return (k == K_MEM_WR) || (k == K_NEXT_WR);
    endfunction

endpackage

// File: rtl/dbg_cmd_decode.sv
module dbg_cmd_decode
    import dbg_cmd_pkg::*;
(
    input  logic [7:0] opcode,
    output cmd_info_t  info
);
    always_comb begin
        info = '{kind: K_BAD, with_stat: 1'b0, wide: 1'b0, active_only: 1'b0,
                 reg_id: REG_A, n_in: 2'd0};
        case (opcode)
            8'hE4: info.kind = K_STAT_RD;
            8'hC4: begin info.kind = K_CTRL_WR; info.n_in = 2'd1; end
            8'hE0: info.kind = K_MEM_RD;
            8'hE1: begin info.kind = K_MEM_RD; info.with_stat = 1'b1; end
            8'hE8: begin info.kind = K_REREAD; info.with_stat = 1'b1; end
            8'hC0: info.kind = K_MEM_WR;
            8'hC1: begin info.kind = K_MEM_WR; info.with_stat = 1'b1; end
            8'hE2: info.kind = K_BKPT_RD;
            8'hC2: begin info.kind = K_BKPT_WR; info.n_in = 2'd2; end
            8'h90: info.kind = K_BGND;
            8'hD5: info.kind = K_ACK_ON;
            8'hD6: info.kind = K_ACK_OFF;
            8'h08, 8'h18: begin info.kind = K_GO; info.active_only = 1'b1; end
            8'h10: begin info.kind = K_TRACE; info.active_only = 1'b1; end
            8'h68, 8'h69, 8'h6B, 8'h6C, 8'h6F: begin
                info.kind        = K_REG_RD;
                info.active_only = 1'b1;
            end
            8'h48, 8'h49, 8'h4B, 8'h4C, 8'h4F: begin
                info.kind        = K_REG_WR;
                info.active_only = 1'b1;
            end
            8'h70, 8'h71: begin
                info.kind        = K_NEXT_RD;
                info.active_only = 1'b1;
                info.with_stat   = opcode[0];
            end
            8'h50, 8'h51: begin
                info.kind        = K_NEXT_WR;
                info.active_only = 1'b1;
                info.with_stat   = opcode[0];
                info.n_in        = 2'd1;
            end
            default: ;
        endcase
        if (info.kind == K_REG_RD || info.kind == K_REG_WR) begin
            case (opcode[2:0])
                3'b000:  info.reg_id = REG_A;
                3'b001:  info.reg_id = REG_CCR;
                3'b011:  info.reg_id = REG_PC;
                3'b100:  info.reg_id = REG_HX;
                default: info.reg_id = REG_SP;
            endcase
            info.wide = (opcode[2:0] != 3'b000) && (opcode[2:0] != 3'b001);
            if (info.kind == K_REG_WR)
                info.n_in = info.wide ? 2'd2 : 2'd1;
        end
    end
endmodule

// File: rtl/dbg_cycle_timer.sv
module dbg_cycle_timer #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
#(
    parameter int WAIT_CYCLES = 3,
    parameter int SYNC_CYCLES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    output logic        rx_ready,
    input  logic [7:0]  rx_byte,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_byte,
    input  logic        sync_req,
    output logic        sync_pulse,
    output logic [15:0] mem_addr,
    output logic        mem_re,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    output logic [2:0]  cpu_reg_sel,
    output logic        cpu_reg_we,
    output logic [15:0] cpu_reg_wdata,
    input  logic [15:0] cpu_reg_rdata,
    output logic        cpu_go,
    output logic        cpu_step,
    input  logic        cpu_step_done,
    output logic        bg_active,
    output logic        ack_en
);
    seq_state_t st_q, st_nxt;
    cmd_info_t  dec;
    cmd_kind_t  kind_q;
    cpu_reg_t   reg_q;
    logic       with_stat_q, wide_q, cnt_q;
    logic [15:0] addr_q, last_addr_q, dbuf_q, bkpt_q;
    logic       bg_en_q, bg_active_q, ack_en_q, err_q, tracing_q;
    logic [7:0] status;
    logic       rx_fire, tx_fire, refuse;
    logic       wait_start, wait_busy, wait_done;
    logic       sync_busy, sync_done;

    dbg_cmd_decode dec_i (.opcode(rx_byte), .info(dec));

    dbg_cycle_timer #(.CYCLES(WAIT_CYCLES)) wait_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(wait_start),
        .busy(wait_busy), .done(wait_done));

    dbg_cycle_timer #(.CYCLES(SYNC_CYCLES)) sync_tmr_i (
        .clk(clk), .rst_n(rst_n), .start(sync_req & (~sync_busy | sync_done)),
        .busy(sync_busy), .done(sync_done));

    assign status  = {bg_en_q, bg_active_q, ack_en_q, err_q, 4'b0000};
    assign rx_fire = rx_valid & rx_ready;
    assign tx_fire = tx_valid & tx_ready;
    assign refuse  = dec.active_only & ~bg_active_q;
    assign wait_start = (st_nxt == S_WAIT) && (st_q != S_WAIT);

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            S_IDLE: if (rx_fire) begin
                if (refuse)
                    st_nxt = (dec.n_in != 2'd0) ? S_DISCARD : S_IDLE;
                else begin
                    case (dec.kind)
                        K_MEM_RD, K_MEM_WR:                      st_nxt = S_ADDR_HI;
                        K_REREAD:                                st_nxt = S_WAIT;
                        K_CTRL_WR, K_BKPT_WR, K_REG_WR, K_NEXT_WR: st_nxt = S_DIN;
                        K_STAT_RD, K_BKPT_RD, K_REG_RD:          st_nxt = S_SEND;
                        K_NEXT_RD:                               st_nxt = S_INC;
                        default:                                 st_nxt = S_IDLE;
                    endcase
                end
            end
            S_ADDR_HI: if (rx_fire) st_nxt = S_ADDR_LO;
            S_ADDR_LO: if (rx_fire) st_nxt = (kind_q == K_MEM_WR) ? S_DIN : S_WAIT;
            S_DIN: if (rx_fire && !cnt_q) begin
                case (kind_q)
                    K_MEM_WR:  st_nxt = S_WAIT;
                    K_NEXT_WR: st_nxt = S_INC;
                    default:   st_nxt = S_IDLE;
                endcase
            end
            S_INC:  st_nxt = S_WAIT;
            S_WAIT: if (wait_done)
                st_nxt = with_stat_q ? S_STAT : (kind_reads(kind_q) ? S_SEND : S_IDLE);
            S_STAT: if (tx_fire) st_nxt = kind_reads(kind_q) ? S_SEND : S_IDLE;
            S_SEND: if (tx_fire && !cnt_q) st_nxt = S_IDLE;
            S_DISCARD: if (rx_fire && !cnt_q) st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            kind_q      <= K_BAD;
            reg_q       <= REG_A;
            with_stat_q <= 1'b0;
            wide_q      <= 1'b0;
            cnt_q       <= 1'b0;
            addr_q      <= '0;
            last_addr_q <= '0;
            dbuf_q      <= '0;
            bkpt_q      <= '0;
            bg_en_q     <= 1'b0;
            bg_active_q <= 1'b0;
            ack_en_q    <= 1'b0;
            err_q       <= 1'b0;
            tracing_q   <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (tracing_q && cpu_step_done) begin
                bg_active_q <= 1'b1;
                tracing_q   <= 1'b0;
            end
            unique case (st_q)
                S_IDLE: if (rx_fire) begin
                    kind_q      <= dec.kind;
                    reg_q       <= dec.reg_id;
                    with_stat_q <= dec.with_stat;
                    wide_q      <= dec.wide;
                    cnt_q       <= (dec.n_in == 2'd2);
                    if (refuse)
                        err_q <= 1'b1;
                    else begin
                        case (dec.kind)
                            K_STAT_RD: begin dbuf_q <= {status, 8'h00}; cnt_q <= 1'b0; end
                            K_BKPT_RD: begin dbuf_q <= bkpt_q; cnt_q <= 1'b1; end
                            K_REG_RD: begin
                                dbuf_q <= dec.wide ? cpu_reg_rdata : {cpu_reg_rdata[7:0], 8'h00};
                                cnt_q  <= dec.wide;
                            end
                            K_REREAD:  addr_q <= last_addr_q;
                            K_BGND:    if (bg_en_q) bg_active_q <= 1'b1;
                            K_ACK_ON:  ack_en_q <= 1'b1;
                            K_ACK_OFF: ack_en_q <= 1'b0;
                            K_GO:      bg_active_q <= 1'b0;
                            K_TRACE: begin
                                bg_active_q <= 1'b0;
                                tracing_q   <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                S_ADDR_HI: if (rx_fire) addr_q[15:8] <= rx_byte;
                S_ADDR_LO: if (rx_fire) begin
                    addr_q[7:0] <= rx_byte;
                    cnt_q       <= 1'b0;
                end
                S_DIN: if (rx_fire) begin
                    dbuf_q <= {dbuf_q[7:0], rx_byte};
                    cnt_q  <= 1'b0;
                    if (!cnt_q) begin
                        if (kind_q == K_CTRL_WR) bg_en_q <= rx_byte[7];
                        if (kind_q == K_BKPT_WR) bkpt_q  <= {dbuf_q[7:0], rx_byte};
                    end
                end
                S_INC:  addr_q <= cpu_reg_rdata + 16'd1;
                S_WAIT: if (wait_done && kind_reads(kind_q)) begin
                    dbuf_q      <= {mem_rdata, 8'h00};
                    last_addr_q <= addr_q;
                    cnt_q       <= 1'b0;
                end
                S_STAT: ;
                S_SEND: if (tx_fire) begin
                    dbuf_q <= {dbuf_q[7:0], 8'h00};
                    cnt_q  <= 1'b0;
                    if (!cnt_q && kind_q == K_STAT_RD) err_q <= 1'b0;
                end
                S_DISCARD: if (rx_fire) cnt_q <= 1'b0;
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rx_ready      = (st_q == S_IDLE) || (st_q == S_ADDR_HI) || (st_q == S_ADDR_LO) ||
                        (st_q == S_DIN)  || (st_q == S_DISCARD);
        tx_valid      = (st_q == S_STAT) || (st_q == S_SEND);
        tx_byte       = (st_q == S_STAT) ? status : dbuf_q[15:8];
        mem_addr      = addr_q;
        mem_wdata     = dbuf_q[7:0];
        mem_re        = (st_q == S_WAIT) && wait_busy && kind_reads(kind_q);
        mem_we        = (st_q == S_WAIT) && wait_busy && kind_writes(kind_q);
        cpu_reg_sel   = dec.reg_id;
        cpu_reg_we    = 1'b0;
        cpu_reg_wdata = wide_q ? {dbuf_q[7:0], rx_byte} : {8'h00, rx_byte};
        if (st_q == S_INC) begin
            cpu_reg_sel   = REG_HX;
            cpu_reg_we    = 1'b1;
            cpu_reg_wdata = cpu_reg_rdata + 16'd1;
        end else if (st_q == S_DIN) begin
            cpu_reg_sel = reg_q;
            cpu_reg_we  = rx_fire && !cnt_q && (kind_q == K_REG_WR);
        end
        cpu_go     = (st_q == S_IDLE) && rx_fire && !refuse && (dec.kind == K_GO);
        cpu_step   = (st_q == S_IDLE) && rx_fire && !refuse && (dec.kind == K_TRACE);
        sync_pulse = sync_busy;
        bg_active  = bg_active_q;
        ack_en     = ack_en_q;
    end
endmodule

// File: rtl/dbg_cmd_seq_chk.sv
module dbg_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ready,
    input logic       tx_valid,
    input logic       tx_ready,
    input logic [7:0] tx_byte,
    input logic       mem_re,
    input logic       mem_we,
    input logic       cpu_reg_we,
    input logic       cpu_go,
    input logic       cpu_step,
    input logic       bg_active,
    input logic       sync_req,
    input logic       sync_pulse
);
    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    assert_mem_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    assert_reg_we_bg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reg_we |-> bg_active);

    assert_run_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_go || cpu_step) |=> !bg_active);

    assert_sync_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_pulse) |-> $past(sync_req));

    assert_io_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_ready && tx_valid));
endmodule

bind dbg_cmd_seq dbg_cmd_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_byte(tx_byte), .mem_re(mem_re), .mem_we(mem_we),
    .cpu_reg_we(cpu_reg_we), .cpu_go(cpu_go), .cpu_step(cpu_step),
    .bg_active(bg_active), .sync_req(sync_req), .sync_pulse(sync_pulse));

// File: tb/dbg_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module dbg_cmd_seq_tb_top;
    localparam int WAITC = 3;
    localparam int SYNCC = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic rx_valid = 1'b0, tx_ready = 1'b0, sync_req = 1'b0, cpu_step_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic rx_ready, tx_valid, sync_pulse, mem_re, mem_we, cpu_reg_we;
    logic cpu_go, cpu_step, bg_active, ack_en;
    logic [7:0] tx_byte, mem_wdata, mem_rdata;
    logic [15:0] mem_addr, cpu_reg_wdata, cpu_reg_rdata;
    logic [2:0] cpu_reg_sel;

    logic [7:0]  mem [256];
    logic [15:0] regs [5];
    int re_cnt = 0, go_cnt = 0, step_cnt = 0;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbg_cmd_seq #(.WAIT_CYCLES(WAITC), .SYNC_CYCLES(SYNCC)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .sync_req(sync_req), .sync_pulse(sync_pulse),
        .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cpu_reg_sel(cpu_reg_sel), .cpu_reg_we(cpu_reg_we),
        .cpu_reg_wdata(cpu_reg_wdata), .cpu_reg_rdata(cpu_reg_rdata),
        .cpu_go(cpu_go), .cpu_step(cpu_step), .cpu_step_done(cpu_step_done),
        .bg_active(bg_active), .ack_en(ack_en));

    // Target memory and CPU register models
    assign mem_rdata     = mem[mem_addr[7:0]];
    assign cpu_reg_rdata = (cpu_reg_sel < 3'd5) ? regs[cpu_reg_sel] : 16'h0000;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'hA5;
            regs[0] <= 16'h0011; regs[1] <= 16'h0022; regs[2] <= 16'h3344;
            regs[3] <= 16'h0040; regs[4] <= 16'h00FF;
        end else begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            if (cpu_reg_we && cpu_reg_sel < 3'd5) regs[cpu_reg_sel] <= cpu_reg_wdata;
        end
        if (mem_re) re_cnt <= re_cnt + 1;
        if (cpu_go) go_cnt <= go_cnt + 1;
        if (cpu_step) step_cnt <= step_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        int g = 0;
        rx_valid = 1'b1;
        rx_byte  = b;
        while (!rx_ready && g < 200) begin @(negedge clk); g++; end
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic expect_byte(input string req, input logic [7:0] exp);
        int g = 0;
        tx_ready = 1'b1;
        while (!tx_valid && g < 200) begin @(negedge clk); g++; end
        chk(req, tx_valid ? int'(tx_byte) : -1, int'(exp));
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 rx_ready", int'(rx_ready), 1);
        chk("R1 tx_valid", int'(tx_valid), 0);
        chk("R1 sync", int'(sync_pulse), 0);
        chk("R1 bg", int'(bg_active), 0);
        send_byte(8'hE4); expect_byte("R1 status", 8'h00);
    endtask

    task automatic t_refuse;
        send_byte(8'h48); send_byte(8'hAB);   // refused write A with operand
        send_byte(8'h68);                     // refused read A
        idle_cycles(5);
        chk("R3 no reply", int'(tx_valid), 0);
        chk("R3 idle", int'(rx_ready), 1);
        send_byte(8'hE4); expect_byte("R3 err set", 8'h10);
        send_byte(8'hE4); expect_byte("R3 err cleared", 8'h00);
    endtask

    task automatic t_unknown;
        send_byte(8'h33);
        idle_cycles(2);
        chk("R13 idle", int'(rx_ready), 1);
        send_byte(8'hE4); expect_byte("R13 no err", 8'h00);
    endtask

    task automatic t_ack;
        send_byte(8'hD5); send_byte(8'hE4); expect_byte("R14 ack on", 8'h20);
        chk("R14 ack pin", int'(ack_en), 1);
        send_byte(8'hD6); send_byte(8'hE4); expect_byte("R14 ack off", 8'h00);
    endtask

    task automatic t_bgnd;
        send_byte(8'h90); send_byte(8'hE4); expect_byte("R2 ignored", 8'h00);
        send_byte(8'hC4); send_byte(8'h80);
        send_byte(8'h90);
        chk("R2 bg pin", int'(bg_active), 1);
        send_byte(8'hE4); expect_byte("R2 entered", 8'hC0);
    endtask

    task automatic t_mem;
        int r0;
        send_byte(8'hC0); send_byte(8'h00); send_byte(8'h12); send_byte(8'h5A);
        idle_cycles(WAITC + 2);
        chk("R4 mem", int'(mem[8'h12]), 8'h5A);
        r0 = re_cnt;
        send_byte(8'hE0); send_byte(8'h00); send_byte(8'h12);
        expect_byte("R5 read", 8'h5A);
        chk("R5 delay", re_cnt - r0, WAITC);
    endtask

    task automatic t_stat_var;
        send_byte(8'hC1); send_byte(8'h00); send_byte(8'h20); send_byte(8'hC3);
        expect_byte("R6 write status", 8'hC0);
        send_byte(8'hE1); send_byte(8'h00); send_byte(8'h20);
        expect_byte("R6 read status", 8'hC0);
        expect_byte("R6 read data", 8'hC3);
    endtask

    task automatic t_reread;
        send_byte(8'hC0); send_byte(8'h00); send_byte(8'h20); send_byte(8'h99);
        idle_cycles(WAITC + 2);
        send_byte(8'hE8);
        expect_byte("R7 status", 8'hC0);
        expect_byte("R7 data", 8'h99);
    endtask

    task automatic t_bkpt;
        send_byte(8'hC2); send_byte(8'hBE); send_byte(8'hEF);
        send_byte(8'hE2);
        expect_byte("R8 high", 8'hBE);
        expect_byte("R8 low", 8'hEF);
    endtask

    task automatic t_regs;
        send_byte(8'h68); expect_byte("R9 A (R3 untouched)", 8'h11);
        send_byte(8'h6B); expect_byte("R9 PC hi", 8'h33); expect_byte("R9 PC lo", 8'h44);
        send_byte(8'h48); send_byte(8'h5C);
        send_byte(8'h68); expect_byte("R9 A written", 8'h5C);
        send_byte(8'h4F); send_byte(8'h12); send_byte(8'h34);
        send_byte(8'h6F); expect_byte("R9 SP hi", 8'h12); expect_byte("R9 SP lo", 8'h34);
        send_byte(8'h69); expect_byte("R9 CCR", 8'h22);
    endtask

    task automatic t_next;
        send_byte(8'h50); send_byte(8'hA1);
        idle_cycles(WAITC + 2);
        chk("R10 write-next mem", int'(mem[8'h41]), 8'hA1);
        send_byte(8'h6C); expect_byte("R10 HX hi", 8'h00); expect_byte("R10 HX lo", 8'h41);
        send_byte(8'h71);
        expect_byte("R10 status", 8'hC0);
        expect_byte("R10 read-next", 8'h42 ^ 8'hA5);
        send_byte(8'h70); expect_byte("R10 read-next plain", 8'h43 ^ 8'hA5);
        send_byte(8'h51); send_byte(8'hB2);
        expect_byte("R10 write-next status", 8'hC0);
        chk("R10 write-next mem2", int'(mem[8'h44]), 8'hB2);
        chk("R10 HX final", int'(regs[3]), 16'h0044);
    endtask

    task automatic t_run;
        int g0, s0;
        g0 = go_cnt;
        send_byte(8'h08);
        chk("R11 go pulse", go_cnt - g0, 1);
        chk("R11 go leaves bg", int'(bg_active), 0);
        send_byte(8'hE4); expect_byte("R11 status after go", 8'h80);
        send_byte(8'h90);
        s0 = step_cnt;
        send_byte(8'h10);
        chk("R11 step pulse", step_cnt - s0, 1);
        chk("R11 trace leaves bg", int'(bg_active), 0);
        cpu_step_done = 1'b1; @(negedge clk); cpu_step_done = 1'b0;
        chk("R11 trace returns", int'(bg_active), 1);
        g0 = go_cnt;
        send_byte(8'h18);
        chk("R11 taggo pulse", go_cnt - g0, 1);
        chk("R11 taggo leaves bg", int'(bg_active), 0);
        send_byte(8'h6B);
        send_byte(8'hE4); expect_byte("R3 refused after go", 8'h90);
    endtask

    task automatic t_sync;
        int hi = 0;
        sync_req = 1'b1; @(negedge clk); sync_req = 1'b0;
        for (int i = 0; i < SYNCC + 6; i++) begin
            if (sync_pulse) hi++;
            @(negedge clk);
        end
        chk("R12 sync width", hi, SYNCC);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_refuse();
        t_unknown();
        t_ack();
        t_bgnd();
        t_mem();
        t_stat_var();
        t_reread();
        t_bkpt();
        t_regs();
        t_next();
        t_run();
        t_sync();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule